// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Generator

This block counts the lines of one display frame and decides on which line vertical blank ends. In fixed mode the frame has a constant total line count. In variable mode the blank can stretch between a shortest and a longest total. Software requests an early end by writing a push. A push that arrives inside the decision window ends the blank on the next line. If no push arrives, the blank ends at the longest point.

Each decision raises a register-latch strobe, which tells shadowed registers to update. Horizontal timing is represented by a single `line_tick` input, so every output moves only on a tick. The mode change requested through `vrr_en` is applied at a frame boundary, so no frame switches mode partway through.

Top module: `vrr_vtimer`

## Requirements
- R1: After reset, `line_cnt` is 0 and every output flag is low. In fixed mode a frame runs through lines 0 to `vtotal_reg`, so its length is `vtotal_reg`+1 lines.
- R2: `vblank` is high on every line at or above `vblank_start`. `frame_start` pulses when the counter returns to line 0, and `vblank` is low on that line.
- R3: In fixed mode, `reg_latch` pulses exactly once per frame, on entry to line `vblank_start`.
- R4: In variable mode, the floor line is max(`flipline_reg`+1, `vmin_reg`+2) − `guardband`. The ceiling line is `vmax_reg`+1 − `guardband`.
  - A push pending on line k gives the decision line D = min(max(k+1, floor), ceiling).
  - `reg_latch` pulses once, on entry to line D.
  - The frame length is D+`guardband`.
- R5: In variable mode with no push, the decision falls on the ceiling line. The frame length is `vmax_reg`+1, and `reg_latch` still pulses.
- R6: A write on `push_wr` is accepted only when `push_wdata` is 2'b11 (bit 1 enable, bit 0 send). Any other value leaves `push_pending` and the frame length unchanged.
- R7: `push_pending` rises one clock after an accepted push. It stays high until the decision line uses it, including across lines below the floor. It is low after the decision.
- R8: A frame that begins in fixed mode clears any pending push. A push made during a fixed frame does not change that frame's length.
- R9: A change on `vrr_en` takes effect only at the next `frame_start`. `vrr_live` shows the mode of the current frame and stays high after `vrr_en` is cleared until that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One-clock pulse per line |
| vrr_en | input | 1 | Request for variable mode |
| vtotal_reg | input | LW | Fixed frame length minus one |
| vblank_start | input | LW | First blank line |
| vmin_reg | input | LW | Minimum total minus one |
| vmax_reg | input | LW | Maximum total minus one |
| flipline_reg | input | LW | Shortest-blank total minus one |
| guardband | input | LW | Lines from decision to frame end |
| push_wr | input | 1 | Push register write strobe |
| push_wdata | input | 2 | Push bits: [1] enable, [0] send |
| line_cnt | output | LW | Current line |
| vblank | output | 1 | Vertical blank flag |
| frame_start | output | 1 | Pulse on entry to line 0 |
| reg_latch | output | 1 | Shadow register latch strobe |
| push_pending | output | 1 | Send bit readback |
| vrr_live | output | 1 | Current frame is in variable mode |

## Verification
The bench builds the block with LW=8, which is wide enough for totals up to 256 lines while keeping frames near fifty lines. It uses two variable-mode setups: one where flipline sets the floor with a five-line guardband, and one where vmin sets the floor with a one-line guardband. This reaches the following corners:
- a push on line 0, held below the floor;
- a push that lands exactly on the ceiling minus one;
- a push with only one bit set;
- enable switched in the middle of a frame.

// File: rtl/vrr_vt_pkg.sv
package vrr_vt_pkg;
    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_TAIL = 1'b1
    } vt_phase_e;

    localparam logic [1:0] PUSH_GO = 2'b11;
endpackage

// File: rtl/vrr_window.sv
module vrr_window #(
    parameter int LW = 12
) (
    input  logic [LW-1:0] flipline_reg,
    input  logic [LW-1:0] vmin_reg,
    input  logic [LW-1:0] vmax_reg,
    input  logic [LW-1:0] guardband,
    output logic [LW-1:0] earliest,
    output logic [LW-1:0] latest
);
    logic [LW-1:0] floor_flip;
    logic [LW-1:0] floor_vmin;
    logic [LW-1:0] floor_tot;

    always_comb begin
        floor_flip = flipline_reg + LW'(1);
        floor_vmin = vmin_reg + LW'(2);
        floor_tot  = (floor_flip > floor_vmin) ? floor_flip : floor_vmin;
        earliest   = floor_tot - guardband;
        latest     = vmax_reg + LW'(1) - guardband;
    end
endmodule

// File: rtl/vrr_push_flag.sv
module vrr_push_flag
    import vrr_vt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] wdata,
    input  logic       consume,
    input  logic       drop,
    output logic       pending
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (consume || drop) pend_d = 1'b0;
        if (wr && (wdata == PUSH_GO)) pend_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pending = pend_q;

    // R6: the send bit can only become set after a write with both bits set
    a_r6_push_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(wr && (wdata == PUSH_GO)));
endmodule

// File: rtl/vrr_vtimer.sv
module vrr_vtimer
    import vrr_vt_pkg::*;
#(
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_tick,
    input  logic          vrr_en,
    input  logic [LW-1:0] vtotal_reg,
    input  logic [LW-1:0] vblank_start,
    input  logic [LW-1:0] vmin_reg,
    input  logic [LW-1:0] vmax_reg,
    input  logic [LW-1:0] flipline_reg,
    input  logic [LW-1:0] guardband,
    input  logic          push_wr,
    input  logic [1:0]    push_wdata,
    output logic [LW-1:0] line_cnt,
    output logic          vblank,
    output logic          frame_start,
    output logic          reg_latch,
    output logic          push_pending,
    output logic          vrr_live
);
    typedef struct packed {
        logic [LW-1:0] cnt;
        logic [LW-1:0] tail_end;
        vt_phase_e     phase;
        logic          live;
        logic          vblank;
        logic          fstart;
        logic          latch;
    } vt_state_t;

    vt_state_t     st_d, st_q;
    logic [LW-1:0] earliest, latest;
    logic [LW-1:0] nxt;
    logic          wrap;
    logic          consume, drop;

    vrr_window #(.LW(LW)) u_window (
        .flipline_reg (flipline_reg),
        .vmin_reg     (vmin_reg),
        .vmax_reg     (vmax_reg),
        .guardband    (guardband),
        .earliest     (earliest),
        .latest       (latest)
    );

    vrr_push_flag u_push (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (push_wr),
        .wdata   (push_wdata),
        .consume (consume),
        .drop    (drop),
        .pending (push_pending)
    );

    always_comb begin
        st_d        = st_q;
        st_d.fstart = 1'b0;
        st_d.latch  = 1'b0;
        consume     = 1'b0;
        drop        = 1'b0;
        nxt         = st_q.cnt + LW'(1);
        if (st_q.live) wrap = (st_q.phase == PH_TAIL) && (st_q.cnt == st_q.tail_end);
        else           wrap = (st_q.cnt == vtotal_reg);
        if (line_tick) begin
            if (wrap) begin
                st_d.cnt    = '0;
                st_d.phase  = PH_RUN;
                st_d.fstart = 1'b1;
                st_d.live   = vrr_en;
                drop        = !vrr_en;
            end else begin
                st_d.cnt = nxt;
                if (st_q.live && (st_q.phase == PH_RUN) && (nxt >= earliest) &&
                    (push_pending || (nxt >= latest))) begin
                    st_d.latch    = 1'b1;
                    st_d.phase    = PH_TAIL;
                    st_d.tail_end = nxt + guardband - LW'(1);
                    consume       = 1'b1;
                end
                if (!st_q.live && (nxt == vblank_start)) st_d.latch = 1'b1;
            end
            st_d.vblank = (st_d.cnt >= vblank_start);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_cnt    = st_q.cnt;
    assign vblank      = st_q.vblank;
    assign frame_start = st_q.fstart;
    assign reg_latch   = st_q.latch;
    assign vrr_live    = st_q.live;

    a_r1_fixed_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !vrr_live |-> (line_cnt <= vtotal_reg));
    a_r2_start_line0: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (line_cnt == '0) && !vblank);
    a_r4_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_latch && vrr_live) |-> (line_cnt >= earliest));
    a_r5_by_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (vrr_live && (st_q.phase == PH_RUN)) |-> (line_cnt < latest));
    a_r9_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |-> $stable(vrr_live));
endmodule

// File: tb/tb_vrr_vtimer.sv
module tb_vrr_vtimer;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_tick = 1'b0;
    logic          vrr_en = 1'b0;
    logic [LW-1:0] vtotal_reg, vblank_start, vmin_reg, vmax_reg, flipline_reg, guardband;
    logic          push_wr = 1'b0;
    logic [1:0]    push_wdata = 2'b00;
    logic [LW-1:0] line_cnt;
    logic          vblank, frame_start, reg_latch, push_pending, vrr_live;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    vrr_vtimer #(.LW(LW)) dut (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .vrr_en(vrr_en),
        .vtotal_reg(vtotal_reg), .vblank_start(vblank_start), .vmin_reg(vmin_reg),
        .vmax_reg(vmax_reg), .flipline_reg(flipline_reg), .guardband(guardband),
        .push_wr(push_wr), .push_wdata(push_wdata), .line_cnt(line_cnt),
        .vblank(vblank), .frame_start(frame_start), .reg_latch(reg_latch),
        .push_pending(push_pending), .vrr_live(vrr_live)
    );

    int c_vt, c_vbs, c_vmin, c_vmax, c_fl, c_gb;

    function automatic int floor_line(int fl, int vm, int gb);
        int a = fl + 1;
        int b = vm + 2;
        return ((a > b) ? a : b) - gb;
    endfunction

    function automatic int decide_line(int k, int lo, int hi);
        int d;
        if (k < 0) return hi;
        d = k + 1;
        if (d < lo) d = lo;
        if (d > hi) d = hi;
        return d;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int vt, input int vbs, input int vmn, input int vmx,
                           input int fl, input int gb);
        c_vt = vt; c_vbs = vbs; c_vmin = vmn; c_vmax = vmx; c_fl = fl; c_gb = gb;
        vtotal_reg   = LW'(vt);
        vblank_start = LW'(vbs);
        vmin_reg     = LW'(vmn);
        vmax_reg     = LW'(vmx);
        flipline_reg = LW'(fl);
        guardband    = LW'(gb);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int div = 0;
        int last_cnt = 0;
        int frame_no = 0;
        int cur_k = -1;
        bit cur_good = 1'b1;
        bit cur_live = 1'b0;
        bit pushed = 1'b0;
        bit just_pushed = 1'b0;
        bit just_good = 1'b0;
        int latch_cnt = 0;
        int latch_line = -1;
        bit en_pend = 1'b0;
        bit en_target = 1'b0;
        int lo, hi, d, exp_len, exp_latch, r;
        string tag;

        void'($urandom(32'd1234));
        set_cfg(29, 20, 23, 44, 24, 5);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_cnt == 0, "R1 reset line", int'(line_cnt), 0);
        chk({vblank, frame_start, reg_latch, push_pending, vrr_live} == 5'b0,
            "R1 reset flags", int'({vblank, frame_start, reg_latch, push_pending, vrr_live}), 0);

        forever begin
            @(negedge clk);
            lo = floor_line(c_fl, c_vmin, c_gb);
            hi = c_vmax + 1 - c_gb;
            if (just_pushed) begin
                chk(push_pending == just_good, just_good ? "R7 pending set" : "R6 ignored push",
                    int'(push_pending), int'(just_good));
                just_pushed = 1'b0;
            end
            if (reg_latch) begin
                latch_cnt++;
                latch_line = line_cnt;
                chk(vrr_live == cur_live, "R9 mode held in frame", int'(vrr_live), int'(cur_live));
                if (!cur_live) chk(vblank == 1'b1, "R2 vblank at latch", int'(vblank), 1);
                else chk(push_pending == 1'b0, "R7 cleared at decision", int'(push_pending), 0);
            end
            if (frame_start) begin
                if (cur_live) begin
                    d = decide_line(cur_good ? cur_k : -1, lo, hi);
                    exp_len = d + c_gb;
                    exp_latch = d;
                    tag = (cur_k >= 0 && cur_good) ? "R4" : "R5";
                end else begin
                    exp_len = c_vt + 1;
                    exp_latch = c_vbs;
                    tag = (cur_k >= 0) ? "R8" : "R1";
                end
                chk(last_cnt + 1 == exp_len, {tag, " frame length"}, last_cnt + 1, exp_len);
                chk(latch_cnt == 1 && latch_line == exp_latch,
                    cur_live ? {tag, " latch line"} : "R3 latch line", latch_line, exp_latch);
                chk(vblank == 1'b0, "R2 vblank low at start", int'(vblank), 0);
                chk(vrr_live == vrr_en, "R9 mode at boundary", int'(vrr_live), int'(vrr_en));
                if (!vrr_en) chk(push_pending == 1'b0, "R8 pending dropped", int'(push_pending), 0);
                frame_no++;
                if (frame_no == 143) break;
                cur_live = vrr_en;
                latch_cnt = 0;
                latch_line = -1;
                pushed = 1'b0;
                cur_k = -1;
                cur_good = 1'b1;
                if (frame_no == 72) begin
                    set_cfg(29, 20, 30, 50, 25, 1);
                    lo = floor_line(c_fl, c_vmin, c_gb);
                    hi = c_vmax + 1 - c_gb;
                end
                if (frame_no == 1) cur_k = 10;
                if (frame_no == 2 || frame_no == 72) begin en_pend = 1'b1; en_target = 1'b1; end
                if (frame_no == 70 || frame_no == 141) begin en_pend = 1'b1; en_target = 1'b0; end
                if (cur_live) begin
                    if (frame_no == 4 || frame_no == 74) cur_k = 0;
                    else if (frame_no == 5 || frame_no == 75) cur_k = hi - 2;
                    else if (frame_no == 6 || frame_no == 76) cur_k = lo - 1;
                    else if (frame_no == 7) begin cur_k = 3; cur_good = 1'b0; end
                    else if (frame_no != 3 && frame_no != 73) begin
                        r = $urandom % 8;
                        if (r >= 2) cur_k = $urandom % (hi - 1);
                        if (r == 2) cur_good = 1'b0;
                    end
                end
            end
            last_cnt = line_cnt;

            line_tick = (div == 3);
            div = (div + 1) % 4;
            push_wr = 1'b0;
            if (!line_tick) begin
                if (cur_k >= 0 && !pushed && line_cnt == LW'(cur_k)) begin
                    push_wr = 1'b1;
                    push_wdata = cur_good ? 2'b11 : 2'($urandom % 3);
                    pushed = 1'b1;
                    just_pushed = 1'b1;
                    just_good = cur_good;
                end
                if (en_pend && line_cnt == LW'(5)) begin
                    vrr_en = en_target;
                    en_pend = 1'b0;
                end
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule